// File: doc/BRIEF.md
# Frame-Synced I/Q Sample Deinterleaver

This block sits behind the capture logic of a two-channel receiver port. Words of `WORD_W` bits come in one per enabled clock, together with a frame-marker bit. Every frame has eight word slots. Those slots carry the upper and lower halves of the I and Q samples of channel A and channel B. The block rebuilds the four full-width samples and presents them together, once per frame, with a one-cycle valid strobe.

The frame marker is high over the channel A half of the frame and low over the channel B half. The marker's phase can move relative to the data after an external resynchronisation, so the block does not rely on a free-running slot counter. It searches for a rising marker edge and treats that word as slot 0. It declares lock only after `LOCK_FRAMES` consecutive frames show the expected marker pattern.

While locked, the block checks every enabled word against the expected marker. If a word disagrees, the block drops lock and emits a one-cycle misalignment pulse. It then begins searching again. A saturating event counter, with its own synchronous clear input, records how many times lock was lost.

Top module: `iq_frame_deint`

## Requirements
- R1: Slot order within a frame is 0:IA upper, 1:QA upper, 2:IA lower, 3:QA lower, 4:IB upper, 5:QB upper, 6:IB lower, 7:QB lower. Each output sample is {upper word, lower word}, with the upper word in the most significant `WORD_W` bits.
- R2: The expected marker is 1 for slots 0 to 3 and 0 for slots 4 to 7. While searching, an enabled word whose marker is 1 after a previous enabled marker of 0 is taken as slot 0. `locked` rises one clock after the slot 7 word of the `LOCK_FRAMES`-th consecutive matching frame counted from that edge.
- R3: `smp_valid` is high for exactly one clock, the clock after the enabled slot 7 word of a frame that was fully received while locked with every marker matching. All four sample outputs update on that same edge and hold their values at all other times.
- R4: `smp_valid` is never high while `locked` is low, and frames completed during the search raise no strobe.
- R5: While locked, an enabled word whose marker differs from the expected value makes `locked` fall and `misalign` pulse high for one clock on the next edge. The search then restarts. If that word is itself a rising marker edge, it becomes slot 0 of the new search.
- R6: When the marker pattern is rotated against the data (for example 1,1,0,0,0,0,1,1), the block reports one misalignment. It then relocks on the new phase after `LOCK_FRAMES` frames.
- R7: Clocks with `ce` low change no state and no output, and raise no pulse.
- R8: `misalign_cnt` grows by one on each `misalign` pulse and saturates at 2^`CNT_W`-1.
- R9: `cnt_clr` sets the counter to 0 on the next edge. If a misalignment occurs on the same edge, the counter becomes 1 instead.
- R10: Synchronous active-high `rst` clears lock, search state, outputs and counter. The remembered marker resets to 0, so a marker of 1 on the first enabled word is a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Qualifies `rx_word` and `rx_sync` |
| rx_word | input | WORD_W | Half-sample data word |
| rx_sync | input | 1 | Frame marker bit |
| cnt_clr | input | 1 | Clears the misalignment counter |
| ia_o | output | 2*WORD_W | Channel A in-phase sample |
| qa_o | output | 2*WORD_W | Channel A quadrature sample |
| ib_o | output | 2*WORD_W | Channel B in-phase sample |
| qb_o | output | 2*WORD_W | Channel B quadrature sample |
| smp_valid | output | 1 | One-clock strobe for a new sample set |
| locked | output | 1 | Frame alignment held |
| misalign | output | 1 | One-clock pulse on loss of alignment |
| misalign_cnt | output | CNT_W | Saturating count of misalignment events |

## Verification
Counter clear and a misalignment increment can land on the same edge. The bench provokes this by raising `cnt_clr` on exactly the enabled word whose marker breaks a held lock. The counter is then judged to read 1, not 0 and not the old value plus one.

The other collision is a marker break that is also a rising edge. There the break and the re-arm of the search happen together. The bench provokes it with a stray high marker in slot 5, and the reference model predicts the resulting relock timing on every clock.

// File: rtl/iq_deint_pkg.sv
package iq_deint_pkg;
   localparam int SLOTS    = 8;
   localparam int SLOT_W   = 3;
   localparam int CHANNELS = 4;
   typedef logic [SLOT_W-1:0] slot_t;

   // channel 0:IA 1:QA 2:IB 3:QB ; upper half slot, lower half two slots later
   function automatic int upper_slot(input int ch);
      return (ch / 2) * 4 + (ch % 2);
   endfunction

   function automatic int lower_slot(input int ch);
      return upper_slot(ch) + 2;
   endfunction
endpackage

// File: rtl/iq_sync_track.sv
module iq_sync_track
   import iq_deint_pkg::*;
#(
   parameter int LOCK_FRAMES = 2
) (
   input  logic  clk,
   input  logic  rst,
   input  logic  ce,
   input  logic  sync_in,
   output slot_t word_slot,
   output logic  frame_done,
   output logic  lost,
   output logic  locked
);
   localparam int FW = $clog2(LOCK_FRAMES + 1);

   logic    prev_q, armed_q, locked_q;
   slot_t   slot_q;
   logic [FW-1:0] frames_q;
   logic    rise, match, good;

   always_comb begin
      rise       = sync_in & ~prev_q;
      match      = (sync_in == ~slot_q[SLOT_W-1]);
      good       = armed_q & match;
      word_slot  = good ? slot_q : '0;
      frame_done = ce & good & locked_q & (slot_q == slot_t'(SLOTS - 1));
      lost       = ce & armed_q & ~match & locked_q;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_q   <= 1'b0;
         armed_q  <= 1'b0;
         locked_q <= 1'b0;
         slot_q   <= '0;
         frames_q <= '0;
      end else if (ce) begin
         prev_q <= sync_in;
         if (good) begin
            slot_q <= slot_q + 1'b1;
            if (slot_q == slot_t'(SLOTS - 1) && !locked_q) begin
               if (frames_q == FW'(LOCK_FRAMES - 1)) begin
                  locked_q <= 1'b1;
                  frames_q <= '0;
               end else begin
                  frames_q <= frames_q + 1'b1;
               end
            end
         end else begin
            locked_q <= 1'b0;
            frames_q <= '0;
            armed_q  <= rise;
            slot_q   <= rise ? slot_t'(1) : slot_t'(0);
         end
      end
   end

   assign locked = locked_q;
endmodule

// File: rtl/iq_word_pack.sv
module iq_word_pack
   import iq_deint_pkg::*;
#(
   parameter int WORD_W = 6
) (
   input  logic                                clk,
   input  logic                                rst,
   input  logic                                ce,
   input  logic [WORD_W-1:0]                   word,
   input  slot_t                               word_slot,
   input  logic                                frame_done,
   output logic [CHANNELS-1:0][2*WORD_W-1:0]   smp,
   output logic                                valid
);
   localparam int SMP_W = 2 * WORD_W;

   logic [CHANNELS-1:0][WORD_W-1:0] lo_src;

   for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
      logic [WORD_W-1:0] hi_q;
      always_ff @(posedge clk) begin
         if (rst)
            hi_q <= '0;
         else if (ce && word_slot == slot_t'(upper_slot(c)))
            hi_q <= word;
      end

      if (lower_slot(c) == SLOTS - 1) begin : g_direct
         assign lo_src[c] = word;
      end else begin : g_held
         logic [WORD_W-1:0] lo_q;
         always_ff @(posedge clk) begin
            if (rst)
               lo_q <= '0;
            else if (ce && word_slot == slot_t'(lower_slot(c)))
               lo_q <= word;
         end
         assign lo_src[c] = lo_q;
      end

      always_ff @(posedge clk) begin
         if (rst)
            smp[c] <= '0;
         else if (frame_done)
            smp[c] <= SMP_W'({hi_q, lo_src[c]});
      end
   end

   always_ff @(posedge clk) begin
      if (rst) valid <= 1'b0;
      else     valid <= frame_done;
   end
endmodule

// File: rtl/iq_evt_count.sv
module iq_evt_count #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clr,
   input  logic             inc,
   output logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W-1:0] CMAX = '1;

   always_ff @(posedge clk) begin
      if (rst)
         cnt <= '0;
      else if (clr)
         cnt <= inc ? CNT_W'(1) : '0;
      else if (inc && cnt != CMAX)
         cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/iq_frame_deint.sv
module iq_frame_deint
   import iq_deint_pkg::*;
#(
   parameter int WORD_W      = 6,
   parameter int LOCK_FRAMES = 2,
   parameter int CNT_W       = 8
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                ce,
   input  logic [WORD_W-1:0]   rx_word,
   input  logic                rx_sync,
   input  logic                cnt_clr,
   output logic [2*WORD_W-1:0] ia_o,
   output logic [2*WORD_W-1:0] qa_o,
   output logic [2*WORD_W-1:0] ib_o,
   output logic [2*WORD_W-1:0] qb_o,
   output logic                smp_valid,
   output logic                locked,
   output logic                misalign,
   output logic [CNT_W-1:0]    misalign_cnt
);
   initial begin
      assert (WORD_W >= 1)      else $error("WORD_W must be at least 1");
      assert (LOCK_FRAMES >= 1) else $error("LOCK_FRAMES must be at least 1");
      assert (CNT_W >= 1)       else $error("CNT_W must be at least 1");
   end

   slot_t word_slot;
   logic  frame_done, lost;
   logic [CHANNELS-1:0][2*WORD_W-1:0] smp;

   iq_sync_track #(.LOCK_FRAMES(LOCK_FRAMES)) u_track (
      .clk(clk), .rst(rst), .ce(ce), .sync_in(rx_sync),
      .word_slot(word_slot), .frame_done(frame_done),
      .lost(lost), .locked(locked)
   );

   iq_word_pack #(.WORD_W(WORD_W)) u_pack (
      .clk(clk), .rst(rst), .ce(ce), .word(rx_word),
      .word_slot(word_slot), .frame_done(frame_done),
      .smp(smp), .valid(smp_valid)
   );

   iq_evt_count #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst), .clr(cnt_clr), .inc(lost), .cnt(misalign_cnt)
   );

   always_ff @(posedge clk) begin
      if (rst) misalign <= 1'b0;
      else     misalign <= lost;
   end

   assign ia_o = smp[0];
   assign qa_o = smp[1];
   assign ib_o = smp[2];
   assign qb_o = smp[3];
endmodule

// File: rtl/iq_frame_deint_chk.sv
module iq_frame_deint_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst,
   input logic             ce,
   input logic             cnt_clr,
   input logic             smp_valid,
   input logic             locked,
   input logic             misalign,
   input logic [CNT_W-1:0] misalign_cnt
);
   localparam logic [CNT_W-1:0] CMAX = '1;

   p_valid_needs_lock_r4: assert property (@(posedge clk) disable iff (rst)
      smp_valid |-> locked);
   p_valid_single_r3: assert property (@(posedge clk) disable iff (rst)
      smp_valid |=> !smp_valid);
   p_misalign_drops_lock_r5: assert property (@(posedge clk) disable iff (rst)
      misalign |-> !locked && $past(locked));
   p_misalign_single_r5: assert property (@(posedge clk) disable iff (rst)
      misalign |=> !misalign);
   p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
      !ce |=> $stable(locked) && !smp_valid && !misalign);
   p_cnt_step_r8: assert property (@(posedge clk) disable iff (rst)
      (!cnt_clr && misalign_cnt != CMAX) |=>
         misalign_cnt == $past(misalign_cnt) + CNT_W'(misalign));
   p_cnt_sat_r8: assert property (@(posedge clk) disable iff (rst)
      (!cnt_clr && misalign_cnt == CMAX) |=> misalign_cnt == CMAX);
   p_cnt_clr_r9: assert property (@(posedge clk) disable iff (rst)
      cnt_clr |=> misalign_cnt == CNT_W'(misalign));
endmodule

bind iq_frame_deint iq_frame_deint_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst(rst), .ce(ce), .cnt_clr(cnt_clr),
   .smp_valid(smp_valid), .locked(locked), .misalign(misalign),
   .misalign_cnt(misalign_cnt)
);

// File: tb/iq_frame_deint_test.sv
module iq_frame_deint_test;
   localparam int W = 6;
   localparam int LF = 2;
   localparam int CW = 8;
   localparam int CMAX = (1 << CW) - 1;

   logic clk = 1'b0;
   logic rst = 1'b1, ce = 1'b0, rx_sync = 1'b0, cnt_clr = 1'b0;
   logic [W-1:0] rx_word = '0;
   logic [2*W-1:0] ia_o, qa_o, ib_o, qb_o;
   logic smp_valid, locked, misalign;
   logic [CW-1:0] misalign_cnt;

   always #2.5 clk = ~clk;

   iq_frame_deint #(.WORD_W(W), .LOCK_FRAMES(LF), .CNT_W(CW)) uut (
      .clk(clk), .rst(rst), .ce(ce), .rx_word(rx_word), .rx_sync(rx_sync),
      .cnt_clr(cnt_clr), .ia_o(ia_o), .qa_o(qa_o), .ib_o(ib_o), .qb_o(qb_o),
      .smp_valid(smp_valid), .locked(locked), .misalign(misalign),
      .misalign_cnt(misalign_cnt)
   );

   int n_checks = 0, n_fail = 0;
   bit done = 0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // reference model: behaviour from the requirements
   int m_lock, m_armed, m_slot, m_frames, m_prev, m_valid, m_mis, m_cnt;
   int m_hi[4], m_lo[4], m_out[4];
   bit m_on = 0;

   function automatic int chan_of_upper(input int s);
      case (s) 0: return 0; 1: return 1; 4: return 2; 5: return 3; default: return -1; endcase
   endfunction
   function automatic int chan_of_lower(input int s);
      case (s) 2: return 0; 3: return 1; 6: return 2; 7: return 3; default: return -1; endcase
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         m_lock = 0; m_armed = 0; m_slot = 0; m_frames = 0; m_prev = 0;
         m_valid = 0; m_mis = 0; m_cnt = 0;
         for (int c = 0; c < 4; c++) begin m_hi[c] = 0; m_lo[c] = 0; m_out[c] = 0; end
      end else begin
         int ev, pos, expect_s, s;
         ev = 0; m_valid = 0;
         if (ce) begin
            s = int'(rx_sync);
            expect_s = (m_slot < 4) ? 1 : 0;
            if (m_armed && s == expect_s) begin
               pos = m_slot;
               if (chan_of_upper(pos) >= 0) m_hi[chan_of_upper(pos)] = int'(rx_word);
               if (chan_of_lower(pos) >= 0) m_lo[chan_of_lower(pos)] = int'(rx_word);
               if (pos == 7) begin
                  if (m_lock) begin
                     for (int c = 0; c < 4; c++) m_out[c] = (m_hi[c] << W) | m_lo[c];
                     m_valid = 1;
                  end else begin
                     m_frames++;
                     if (m_frames == LF) begin m_lock = 1; m_frames = 0; end
                  end
               end
               m_slot = (m_slot + 1) % 8;
            end else begin
               if (m_armed && m_lock) ev = 1;
               m_lock = 0; m_frames = 0;
               if (s == 1 && m_prev == 0) begin
                  m_armed = 1; m_slot = 1; m_hi[0] = int'(rx_word);
               end else begin
                  m_armed = 0; m_slot = 0; m_hi[0] = int'(rx_word);
               end
            end
            m_prev = s;
         end
         m_mis = ev;
         if (cnt_clr) m_cnt = ev;
         else if (ev && m_cnt < CMAX) m_cnt++;
      end
      m_on = 1;
   end

   always @(negedge clk) if (m_on && !rst && !done) begin
      chk(smp_valid == m_valid[0], "R4 smp_valid", smp_valid, m_valid);
      chk(locked == m_lock[0], "R2 locked", locked, m_lock);
      chk(misalign == m_mis[0], "R5 misalign", misalign, m_mis);
      chk(misalign_cnt == CW'(m_cnt), "R8 misalign_cnt", misalign_cnt, m_cnt);
      chk(ia_o == 12'(m_out[0]) && qa_o == 12'(m_out[1]) &&
          ib_o == 12'(m_out[2]) && qb_o == 12'(m_out[3]),
          "R3 samples", {ia_o, qa_o, ib_o, qb_o},
          {12'(m_out[0]), 12'(m_out[1]), 12'(m_out[2]), 12'(m_out[3])});
   end

   task automatic send(input logic [W-1:0] w, input logic s, input logic clr);
      @(negedge clk);
      ce = 1'b1; rx_word = w; rx_sync = s; cnt_clr = clr;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         ce = 1'b0; cnt_clr = 1'b0; rx_word = ~rx_word; rx_sync = ~rx_sync;
      end
   endtask

   // pattern bit 7 is slot 0; clr_slot < 0 means no clear
   task automatic frame(input int base, input logic [7:0] pat, input int gap, input int clr_slot);
      for (int i = 0; i < 8; i++) begin
         send(W'(base + i * 5), pat[7-i], i == clr_slot);
         if (gap > 0) idle(gap);
      end
   endtask

   task automatic settle();
      @(negedge clk);
      ce = 1'b0; cnt_clr = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk(!locked && !smp_valid && misalign_cnt == 0 && ia_o == 0, "R10 reset state",
          {locked, smp_valid, misalign_cnt}, 0);

      for (int f = 0; f < LF; f++) frame(f * 3, 8'hF0, 0, -1);
      settle();
      chk(locked == 1'b1, "R2 lock after matching frames", locked, 1);
      chk(smp_valid == 1'b0, "R4 no strobe for lock frames", smp_valid, 0);

      frame(9, 8'hF0, 0, -1);
      @(negedge clk);
      ce = 1'b0;
      chk(smp_valid == 1'b1, "R3 strobe after slot 7", smp_valid, 1);
      chk(ia_o == {6'(9), 6'(19)}, "R1 IA upper/lower", ia_o, {6'(9), 6'(19)});
      chk(qb_o == {6'(34), 6'(44)}, "R1 QB upper/lower", qb_o, {6'(34), 6'(44)});
      chk(ib_o == {6'(29), 6'(39)}, "R1 IB upper/lower", ib_o, {6'(29), 6'(39)});

      for (int f = 0; f < 3; f++) frame(20 + f, 8'hF0, 2, -1);
      idle(4);
      chk(locked == 1'b1 && misalign_cnt == 0, "R7 gaps keep lock", locked, 1);

      for (int f = 0; f < 5; f++) frame(40 + f, 8'hC3, 0, -1);
      settle();
      chk(locked == 1'b1, "R6 relock on rotated marker", locked, 1);
      chk(misalign_cnt == 1, "R6 single misalignment", misalign_cnt, 1);

      for (int k = 0; k < 262; k++) begin
         for (int f = 0; f < LF + 1; f++) frame(k + f, 8'hF0, 0, -1);
         frame(k, 8'hF4, 0, -1);
      end
      settle();
      chk(misalign_cnt == CW'(CMAX), "R8 counter saturates", misalign_cnt, CMAX);

      for (int f = 0; f < LF + 1; f++) frame(f, 8'hF0, 0, -1);
      frame(7, 8'hF4, 0, 5);
      settle();
      chk(misalign_cnt == 1, "R9 clear with event gives one", misalign_cnt, 1);
      chk(locked == 1'b0, "R5 lock dropped", locked, 0);

      send(6'd1, 1'b0, 1'b1);
      settle();
      chk(misalign_cnt == 0, "R9 clear alone", misalign_cnt, 0);

      idle(3);
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_checks++; n_fail++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end
endmodule